// File: doc/BRIEF.md
# Five-Port Parallel I/O Controller

This block gives an 8-bit CPU five bidirectional 8-bit parallel ports on its I/O bus. Each port owns two registers: a data latch holding the value the CPU wants to drive, and a direction mask choosing, bit by bit, whether that bit drives (1) or listens (0). The CPU reaches the ten registers through single-byte I/O addresses. Only the low address byte is decoded, so each register repeats across every value of the high byte.

Each port presents its drive value and an output-enable mask, so a pad ring can build tri-state buffers from them. Bits set as inputs present a logic 1 on the drive value. When the CPU reads a port's data address, it gets the pin level on input bits and the latched value on output bits. Accesses to other low-byte addresses are left to neighbouring peripherals. For those the block keeps its hit flag low and returns all ones.

Top module: `pio5_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every direction mask to 0x00 and every data latch to 0xFF, so every port drives 0xFF with output enable 0x00.
- R2: A write (cs and wr high at a rising clock edge) to a data address stores wdata in that port's latch. Low-byte data addresses: port A 0x50, B 0x51, C 0x52, D 0x30, E 0x40.
- R3: Each port's drive value is latch OR NOT direction, and its output enable equals the direction mask. Both follow the registers combinationally, so a direction write alone changes the drive value right after its clock edge.
- R4: A read (cs and rd high) of a data address returns, per bit, the pin input where the direction bit is 0 and the latch bit where it is 1. hit is high during that read.
- R5: A write to a direction address stores wdata in that port's direction mask, and a read of it returns the stored value unchanged. Low-byte direction addresses: A 0x54, B 0x55, C 0x56, D 0x34, E 0x44.
- R6: Address bits 15:8 take no part in decoding, so every register answers at all 256 high-byte values.
- R7: A read of a low-byte address outside the ten listed returns 0xFF with hit low. A write to such an address changes no register.
- R8: A write strobe without cs changes no register. When no access is present, hit is low and rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select for I/O cycles |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, acted on at the rising edge |
| addr | input | 16 | I/O address; only bits 7:0 decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational; 0xFF when not hit |
| hit | output | 1 | High while a read targets one of this block's registers |
| pin_in | input | 40 | Pin levels, port A in bits 7:0 up to port E in bits 39:32 |
| port_out | output | 40 | Drive values, same packing as pin_in |
| port_oe | output | 40 | Output enables (1 = drive), same packing |

## Verification
On every cycle, the assertions check several properties. The reset values appear when reset releases. A direction load lands exactly the written byte. An idle latch holds, and input-configured bits drive high. At most one register matches any address. Without a selected write, no drive value or enable moves. The bench's reference model shows what only scenarios can reveal: the bit-wise merge on reads against changing pin patterns, that mirrored high-byte addresses reach the same register, and that reads and writes at unlisted addresses return 0xFF and leave every port untouched.

// File: rtl/pio5_pkg.sv
package pio5_pkg;
  localparam int unsigned PIO_PORTS = 5;
  localparam int unsigned PIO_W     = 8;
  localparam int unsigned PIO_DEC_W = 8;
  // Low-byte register addresses, port A in the lowest slot.
  localparam logic [PIO_PORTS*PIO_DEC_W-1:0] PIO_DATA_MAP = {8'h40, 8'h30, 8'h52, 8'h51, 8'h50};
  localparam logic [PIO_PORTS*PIO_DEC_W-1:0] PIO_DIR_MAP  = {8'h44, 8'h34, 8'h56, 8'h55, 8'h54};
endpackage

// File: rtl/pio5_decode.sv
module pio5_decode #(
  parameter int unsigned N      = 5,
  parameter int unsigned DEC_W  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [N*DEC_W-1:0] DATA_MAP = '0,
  parameter logic [N*DEC_W-1:0] DIR_MAP  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      data_sel,
  output logic [N-1:0]      dir_sel
);
  logic [DEC_W-1:0] low;
  assign low = addr[DEC_W-1:0];

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign data_sel[k] = (low == DATA_MAP[k*DEC_W +: DEC_W]);
    assign dir_sel[k]  = (low == DIR_MAP[k*DEC_W +: DEC_W]);
  end
endmodule

// File: rtl/pio5_port.sv
module pio5_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_latch,
  input  logic         ld_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] dir_val,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '0;
    end else begin
      if (ld_latch) latch_q <= wdata;
      if (ld_dir)   dir_q   <= wdata;
    end
  end

  assign pad_out = latch_q | ~dir_q;
  assign pad_oe  = dir_q;
  assign dir_val = dir_q;
  assign rd_val  = (pin & ~dir_q) | (latch_q & dir_q);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dir_q == '0 && latch_q == '1));

  assert_dir_load_R5: assert property (@(posedge clk) disable iff (rst)
    ld_dir |=> (dir_val == $past(wdata)));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ld_latch |=> $stable(latch_q));

  assert_inputs_drive_high_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_out | pad_oe) == '1);
endmodule

// File: rtl/pio5_rdmux.sv
module pio5_rdmux #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   data_sel,
  input  logic [N-1:0]   dir_sel,
  input  logic [N*W-1:0] port_rd,
  input  logic [N*W-1:0] port_dir,
  output logic [W-1:0]   mux_out,
  output logic           any_sel
);
  always_comb begin
    mux_out = '0;
    for (int k = 0; k < N; k++) begin
      if (data_sel[k]) mux_out = mux_out | port_rd[k*W +: W];
      if (dir_sel[k])  mux_out = mux_out | port_dir[k*W +: W];
    end
  end
  assign any_sel = |{data_sel, dir_sel};
endmodule

// File: rtl/pio5_ctrl.sv
module pio5_ctrl #(
  parameter int unsigned NUM_PORTS = pio5_pkg::PIO_PORTS,
  parameter int unsigned PORT_W    = pio5_pkg::PIO_W,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEC_W     = pio5_pkg::PIO_DEC_W,
  parameter logic [NUM_PORTS*DEC_W-1:0] DATA_MAP = pio5_pkg::PIO_DATA_MAP,
  parameter logic [NUM_PORTS*DEC_W-1:0] DIR_MAP  = pio5_pkg::PIO_DIR_MAP
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs,
  input  logic                          rd,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PORT_W-1:0]             wdata,
  output logic [PORT_W-1:0]             rdata,
  output logic                          hit,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   port_out,
  output logic [NUM_PORTS*PORT_W-1:0]   port_oe
);
  localparam int unsigned BUS_W = NUM_PORTS * PORT_W;

  logic [NUM_PORTS-1:0] data_sel, dir_sel;
  logic [BUS_W-1:0]     rd_bus, dir_bus;
  logic [PORT_W-1:0]    mux_out;
  logic                 any_sel;
  logic                 wr_go;

  assign wr_go = cs & wr;

  pio5_decode #(
    .N(NUM_PORTS), .DEC_W(DEC_W), .ADDR_W(ADDR_W),
    .DATA_MAP(DATA_MAP), .DIR_MAP(DIR_MAP)
  ) u_dec (
    .addr(addr), .data_sel(data_sel), .dir_sel(dir_sel)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    pio5_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .ld_latch (wr_go & data_sel[k]),
      .ld_dir   (wr_go & dir_sel[k]),
      .wdata    (wdata),
      .pin      (pin_in[k*PORT_W +: PORT_W]),
      .pad_out  (port_out[k*PORT_W +: PORT_W]),
      .pad_oe   (port_oe[k*PORT_W +: PORT_W]),
      .dir_val  (dir_bus[k*PORT_W +: PORT_W]),
      .rd_val   (rd_bus[k*PORT_W +: PORT_W])
    );
  end

  pio5_rdmux #(.N(NUM_PORTS), .W(PORT_W)) u_mux (
    .data_sel (data_sel),
    .dir_sel  (dir_sel),
    .port_rd  (rd_bus),
    .port_dir (dir_bus),
    .mux_out  (mux_out),
    .any_sel  (any_sel)
  );

  assign hit   = cs & rd & any_sel;
  assign rdata = hit ? mux_out : '1;

  // R6: a single low byte can never select two registers.
  assert_single_target_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_sel, dir_sel}));

  assert_no_select_no_change_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> ($stable(port_out) && $stable(port_oe)));
endmodule

// File: tb/sim_pio5_ctrl.sv
module sim_pio5_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit;
  logic [39:0] pin_in = '0;
  logic [39:0] port_out, port_oe;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;

  logic [7:0] m_lat [NP];
  logic [7:0] m_dir [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio5_ctrl u0 (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hit(hit), .pin_in(pin_in),
    .port_out(port_out), .port_oe(port_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench address map: returns port index 0..4 or -1.
  function automatic int data_port(input logic [7:0] a);
    case (a)
      8'h50: return 0; 8'h51: return 1; 8'h52: return 2;
      8'h30: return 3; 8'h40: return 4;
      default: return -1;
    endcase
  endfunction
  function automatic int dir_port(input logic [7:0] a);
    case (a)
      8'h54: return 0; 8'h55: return 1; 8'h56: return 2;
      8'h34: return 3; 8'h44: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NP; k++) begin m_lat[k] = 8'hFF; m_dir[k] = 8'h00; end
  endtask

  // Reference model compared on every clock (R3 drive values and enables).
  always @(negedge clk) begin
    if (running && !rst) begin
      for (int k = 0; k < NP; k++) begin
        check(port_out[k*8 +: 8] == (m_lat[k] | ~m_dir[k]), "R3 port_out",
              {8'h0, port_out[k*8 +: 8]}, {8'h0, m_lat[k] | ~m_dir[k]});
        check(port_oe[k*8 +: 8] == m_dir[k], "R3 port_oe",
              {8'h0, port_oe[k*8 +: 8]}, {8'h0, m_dir[k]});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (sel) begin
      if (data_port(a[7:0]) >= 0) m_lat[data_port(a[7:0])] = d;
      if (dir_port(a[7:0]) >= 0)  m_dir[dir_port(a[7:0])] = d;
    end
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [7:0] exp_d;
    logic       exp_h;
    int dp, rp;
    dp = data_port(a[7:0]);
    rp = dir_port(a[7:0]);
    exp_h = 1'b1;
    if (dp >= 0)      exp_d = (pin_in[dp*8 +: 8] & ~m_dir[dp]) | (m_lat[dp] & m_dir[dp]);
    else if (rp >= 0) exp_d = m_dir[rp];
    else begin exp_d = 8'hFF; exp_h = 1'b0; end
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #2;
    check(rdata == exp_d, {tag, " rdata"}, {8'h0, rdata}, {8'h0, exp_d});
    check(hit == exp_h, {tag, " hit"}, {15'h0, hit}, {15'h0, exp_h});
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] dmap [NP];
    logic [7:0] rmap [NP];
    dmap = '{8'h50, 8'h51, 8'h52, 8'h30, 8'h40};
    rmap = '{8'h54, 8'h55, 8'h56, 8'h34, 8'h44};
    model_reset();
    do_reset();
    running = 1'b1;

    // R1: reset state at the ports and through readback
    @(negedge clk);
    check(port_out == {40{1'b1}}, "R1 out after reset", port_out[15:0], 16'hFFFF);
    check(port_oe == '0, "R1 oe after reset", port_oe[15:0], 16'h0);
    for (int k = 0; k < NP; k++) do_read({8'h00, rmap[k]}, "R1 dir readback");

    // R8: idle bus reads as ones with hit low
    #2;
    check(rdata == 8'hFF && hit == 1'b0, "R8 idle bus", {7'h0, hit, rdata}, 16'h00FF);

    // R4: all inputs, reads follow the pins
    pin_in = 40'h13_57_9B_DF_A5;
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R4 pins only");

    // R2: latches load, outputs stay high while inputs
    for (int k = 0; k < NP; k++) do_write({8'h00, dmap[k]}, 8'h11 * (k + 1), 1'b1);
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R2 latch hidden by inputs");

    // R5 and R3: direction writes expose latch bits immediately
    do_write(16'h0054, 8'hF0, 1'b1);
    do_write(16'h0034, 8'h0F, 1'b1);
    do_write(16'h0044, 8'hFF, 1'b1);
    do_write(16'h0055, 8'hA5, 1'b1);
    for (int k = 0; k < NP; k++) do_read({8'h00, rmap[k]}, "R5 dir readback");
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R4 merged read");

    // R4: new pin pattern, mixed directions
    pin_in = 40'hC3_3C_00_FF_5A;
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R4 second pattern");

    // R6: mirrored high bytes
    do_write(16'hAB51, 8'h69, 1'b1);
    do_write(16'hFF55, 8'hFF, 1'b1);
    do_read(16'h1251, "R6 mirror data");
    do_read(16'hFF55, "R6 mirror dir");
    do_read(16'h8030, "R6 mirror port D");
    do_write(16'h7F40, 8'h3C, 1'b1);
    do_read(16'h0040, "R6 mirror write E");

    // R7: unlisted addresses
    do_read(16'h0053, "R7 unlisted 53");
    do_read(16'h0000, "R7 unlisted 00");
    do_read(16'hFF57, "R7 unlisted 57");
    do_read(16'h0150, "R7 neighbour decoded 50 hit");
    do_write(16'h0053, 8'h00, 1'b1);
    do_write(16'h0035, 8'h00, 1'b1);
    for (int k = 0; k < NP; k++) do_read({8'h00, rmap[k]}, "R7 dirs untouched");
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R7 data untouched");

    // R8: write strobe without chip select
    do_write(16'h0054, 8'h00, 1'b0);
    do_write(16'h0050, 8'h00, 1'b0);
    do_read(16'h0054, "R8 dir kept");
    do_read(16'h0050, "R8 latch kept");

    // R3: full-output port drives its latch
    do_write(16'h0052, 8'h81, 1'b1);
    do_write(16'h0056, 8'hFF, 1'b1);
    @(negedge clk);
    check(port_out[23:16] == 8'h81, "R3 all outputs", {8'h0, port_out[23:16]}, 16'h0081);

    // R1: reset again mid-run
    do_reset();
    @(negedge clk);
    check(port_out == {40{1'b1}} && port_oe == '0, "R1 second reset",
          port_oe[15:0], 16'h0);
    for (int k = 0; k < NP; k++) do_read({8'h00, dmap[k]}, "R1 reads pins after reset");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule